// File: doc/BRIEF.md
# Guarded Signed Halfword Load Unit

This block sits in the load stage of a wide-issue processor core. For each issued load it reads two consecutive bytes of byte-addressed data memory, places them in a 16-bit value in the byte order picked by a runtime control bit, sign-extends the value to a 32-bit word and hands it to the register-file write port. Writeback and every other effect of the load, including the memory read, depend only on the least significant bit of the guard operand.

The unit is fully pipelined. It accepts one issue per clock and delivers each result a fixed number of cycles later. The guard bit, the destination index and the byte-order bit are latched at issue and travel with the access, so a change of mode after issue has no effect on loads already in flight.

An odd address is not treated as an error. The two bytes at the address and the address plus one are used exactly as for an aligned address, and the pipeline does not stall. An address inside a configurable memory-mapped I/O window issues no memory read. Its result is the placeholder value zero, and it raises no cache-status strobe.

Top module: `hword_load_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `mem_req_o`, `wr_en_o` and `cache_upd_o` are 0. A load that is still in flight when reset is asserted never produces a write.
- R2: An issue sampled at clock edge k with guard 1 drives `wr_en_o` high for exactly one cycle, from edge k+3 to edge k+4. A new issue is accepted every cycle, and back-to-back issues give back-to-back writes in issue order.
- R3: When the byte-order bit is 0 (little-endian), the byte at address A lands in result bits 7:0 and the byte at A+1 lands in bits 15:8.
- R4: When the byte-order bit is 1 (big-endian), the byte at address A lands in result bits 15:8 and the byte at A+1 lands in bits 7:0.
- R5: Result bits 31:16 all equal bit 15 of the assembled halfword.
- R6: When the guard is 0, the load issues no memory request, no register write and no cache-status strobe.
- R7: A guarded issue at edge k with an address outside the I/O window drives `mem_req_o` high during the cycle between edges k and k+1, with `mem_addr_o` equal to the issue address. `mem_rdata_i` is sampled one cycle later: bits 7:0 hold the byte at A and bits 15:8 hold the byte at A+1.
- R8: `cache_upd_o` rises together with `wr_en_o` for every guarded load outside the I/O window, and it is never high without `wr_en_o`.
- R9: When address bits 31:21 equal bits 31:21 of the window base (default 0xEFE0_0000), the load issues no memory request. It writes 0 to its destination and gives no cache-status strobe.
- R10: An odd address uses the bytes at A and A+1 with the selected byte order. It has the same latency as an aligned address and does not stall.
- R11: The destination index and the byte order used for a result are the values presented with that load's issue, whatever is presented later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid_i | input | 1 | Load issue strobe |
| iss_addr_i | input | 32 | Byte address of the halfword |
| iss_guard_i | input | 1 | Least significant bit of the guard operand |
| iss_dst_i | input | 7 | Destination register index |
| iss_big_i | input | 1 | Byte order: 0 little-endian, 1 big-endian |
| mem_req_o | output | 1 | Data-memory read request |
| mem_addr_o | output | 32 | Data-memory read address |
| mem_rdata_i | input | 16 | Bytes at A (7:0) and A+1 (15:8), one cycle after the request |
| wr_en_o | output | 1 | Register write enable |
| wr_idx_o | output | 7 | Register write index |
| wr_data_o | output | 32 | Register write data |
| cache_upd_o | output | 1 | Cache-status update strobe |

## Verification
On every cycle the assertions check four things: a memory request only follows a guarded issue one cycle earlier, no request ever targets the I/O window, the cache strobe never appears without a write, and a write never occurs without a guarded load still outstanding. A window write that carries no cache strobe must also carry zero data. Only the bench scenarios can show the actual byte placement for both orders and the sign extension of concrete values. They also cover the handling of odd addresses, the exact three-cycle result timing, per-load capture of mode and index while the controls toggle every cycle, and the loss of in-flight loads at reset.

// File: rtl/hlu_pkg.sv
package hlu_pkg;
   typedef enum logic {
      BO_LITTLE = 1'b0,
      BO_BIG    = 1'b1
   } byte_order_e;

   localparam int BYTE_W = 8;
   localparam int HALF_W = 2 * BYTE_W;
endpackage

// File: rtl/hlu_region_check.sv
module hlu_region_check #(
   parameter int                ADDR_W    = 32,
   parameter int                SPAN_LOG2 = 21,
   parameter logic [ADDR_W-1:0] BASE      = 32'hEFE0_0000
) (
   input  logic [ADDR_W-SPAN_LOG2-1:0] tag_i,
   output logic                        hit_o
);
   localparam int TAG_W = ADDR_W - SPAN_LOG2;
   localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:SPAN_LOG2];

   generate
      if (TAG_W < 1) begin : g_bad_span
         $error("hlu_region_check: window span must leave tag bits");
      end
   endgenerate

   assign hit_o = (tag_i == BASE_TAG);
endmodule

// File: rtl/hlu_meta_pipe.sv
module hlu_meta_pipe #(
   parameter int W     = 9,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vld_i,
   input  logic [W-1:0] dat_i,
   output logic         vld_o,
   output logic [W-1:0] dat_o
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("hlu_meta_pipe: DEPTH must be at least 1");
      end

      for (genvar g = 0; g < DEPTH; g++) begin : g_stg
         logic         vin;
         logic [W-1:0] din;
         logic         vq;
         logic [W-1:0] dq;

         if (g == 0) begin : g_head
            assign vin = vld_i;
            assign din = dat_i;
         end else begin : g_link
            assign vin = g_stg[g-1].vq;
            assign din = g_stg[g-1].dq;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vq <= 1'b0;
               dq <= '0;
            end else begin
               vq <= vin;
               dq <= din;
            end
         end
      end
   endgenerate

   assign vld_o = g_stg[DEPTH-1].vq;
   assign dat_o = g_stg[DEPTH-1].dq;
endmodule

// File: rtl/hlu_half_format.sv
module hlu_half_format #(
   parameter int OUT_W    = 32,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic [hlu_pkg::HALF_W-1:0] pair_i,
   input  logic                       big_i,
   input  logic                       zero_i,
   output logic [OUT_W-1:0]           word_o
);
   import hlu_pkg::*;

   localparam int PAD_W = OUT_W - HALF_W;

   logic [HALF_W-1:0] half;
   logic [OUT_W-1:0]  ext;

   generate
      if (PAD_W < 1) begin : g_bad_width
         $error("hlu_half_format: OUT_W must exceed the halfword width");
      end
   endgenerate

   always_comb begin
      if (byte_order_e'(big_i) == BO_BIG)
         half = {pair_i[BYTE_W-1:0], pair_i[HALF_W-1:BYTE_W]};
      else
         half = pair_i;
   end

   generate
      if (SIGN_EXT) begin : g_signed
         assign ext = {{PAD_W{half[HALF_W-1]}}, half};
      end else begin : g_unsigned
         assign ext = {{PAD_W{1'b0}}, half};
      end
   endgenerate

   assign word_o = zero_i ? '0 : ext;
endmodule

// File: rtl/hword_load_unit.sv
module hword_load_unit #(
   parameter int                ADDR_W     = 32,
   parameter int                WORD_W     = 32,
   parameter int                NUM_REGS   = 128,
   parameter int                MEM_LAT    = 1,
   parameter bit                SIGN_EXT   = 1'b1,
   parameter int                IO_LOG2    = 21,
   parameter logic [ADDR_W-1:0] IO_BASE    = 32'hEFE0_0000,
   localparam int               IDX_W      = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       iss_valid_i,
   input  logic [ADDR_W-1:0]          iss_addr_i,
   input  logic                       iss_guard_i,
   input  logic [IDX_W-1:0]           iss_dst_i,
   input  logic                       iss_big_i,
   output logic                       mem_req_o,
   output logic [ADDR_W-1:0]          mem_addr_o,
   input  logic [hlu_pkg::HALF_W-1:0] mem_rdata_i,
   output logic                       wr_en_o,
   output logic [IDX_W-1:0]           wr_idx_o,
   output logic [WORD_W-1:0]          wr_data_o,
   output logic                       cache_upd_o
);
   import hlu_pkg::*;

   localparam int META_W   = IDX_W + 2;
   localparam int LOAD_LAT = MEM_LAT + 2;
   localparam int PEND_W   = $clog2(LOAD_LAT + 2) + 1;

   generate
      if (MEM_LAT < 1) begin : g_bad_lat
         $error("hword_load_unit: MEM_LAT must be at least 1");
      end
      if (IO_LOG2 >= ADDR_W || IO_LOG2 < 1) begin : g_bad_span
         $error("hword_load_unit: IO_LOG2 out of range");
      end else if (IO_BASE[IO_LOG2-1:0] != '0) begin : g_bad_base
         $error("hword_load_unit: IO_BASE not aligned to its span");
      end
      if (NUM_REGS < 2) begin : g_bad_regs
         $error("hword_load_unit: NUM_REGS must be at least 2");
      end
   endgenerate

   // Issue stage
   logic              acc;
   logic              io_hit;
   logic              s1_v;
   logic [ADDR_W-1:0] s1_addr;
   logic [IDX_W-1:0]  s1_idx;
   logic              s1_big;
   logic              s1_io;

   assign acc = iss_valid_i & iss_guard_i;

   hlu_region_check #(
      .ADDR_W    (ADDR_W),
      .SPAN_LOG2 (IO_LOG2),
      .BASE      (IO_BASE)
   ) u_region (
      .tag_i (iss_addr_i[ADDR_W-1:IO_LOG2]),
      .hit_o (io_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_addr <= '0;
         s1_idx  <= '0;
         s1_big  <= 1'b0;
         s1_io   <= 1'b0;
      end else begin
         s1_v <= acc;
         if (acc) begin
            s1_addr <= iss_addr_i;
            s1_idx  <= iss_dst_i;
            s1_big  <= iss_big_i;
            s1_io   <= io_hit;
         end
      end
   end

   assign mem_req_o  = s1_v & ~s1_io;
   assign mem_addr_o = s1_addr;

   // Metadata carried alongside the memory access
   logic              p_v;
   logic [META_W-1:0] p_meta;

   hlu_meta_pipe #(
      .W     (META_W),
      .DEPTH (MEM_LAT)
   ) u_meta (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (s1_v),
      .dat_i ({s1_idx, s1_big, s1_io}),
      .vld_o (p_v),
      .dat_o (p_meta)
   );

   // Capture stage
   logic              c_v;
   logic [IDX_W-1:0]  c_idx;
   logic              c_big;
   logic              c_io;
   logic [HALF_W-1:0] c_pair;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_v    <= 1'b0;
         c_idx  <= '0;
         c_big  <= 1'b0;
         c_io   <= 1'b0;
         c_pair <= '0;
      end else begin
         c_v <= p_v;
         if (p_v) begin
            {c_idx, c_big, c_io} <= p_meta;
            c_pair               <= mem_rdata_i;
         end
      end
   end

   // Format and writeback stage
   logic [WORD_W-1:0] fmt_word;

   hlu_half_format #(
      .OUT_W    (WORD_W),
      .SIGN_EXT (SIGN_EXT)
   ) u_fmt (
      .pair_i (c_pair),
      .big_i  (c_big),
      .zero_i (c_io),
      .word_o (fmt_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_o     <= 1'b0;
         wr_idx_o    <= '0;
         wr_data_o   <= '0;
         cache_upd_o <= 1'b0;
      end else begin
         wr_en_o     <= c_v;
         cache_upd_o <= c_v & ~c_io;
         if (c_v) begin
            wr_idx_o  <= c_idx;
            wr_data_o <= fmt_word;
         end
      end
   end

   // Outstanding guarded loads, kept for the checks below
   logic [PEND_W-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= '0;
      else
         pend_q <= pend_q + PEND_W'(acc) - PEND_W'(wr_en_o);
   end

   // R2
   write_has_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (pend_q != '0));

   // R6
   req_after_guarded_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> $past(iss_valid_i && iss_guard_i));

   // R8
   cache_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cache_upd_o |-> wr_en_o);

   // R9
   no_io_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (mem_addr_o[ADDR_W-1:IO_LOG2] != IO_BASE[ADDR_W-1:IO_LOG2]));

   // R9
   io_write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && !cache_upd_o) |-> (wr_data_o == '0));
endmodule

// File: tb/sim_hword_load_unit.sv
module sim_hword_load_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_valid_i = 1'b0;
   logic [31:0] iss_addr_i = '0;
   logic        iss_guard_i = 1'b0;
   logic [6:0]  iss_dst_i = '0;
   logic        iss_big_i = 1'b0;
   logic        mem_req_o;
   logic [31:0] mem_addr_o;
   logic [15:0] mem_rdata_i = '0;
   logic        wr_en_o;
   logic [6:0]  wr_idx_o;
   logic [31:0] wr_data_o;
   logic        cache_upd_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   hword_load_unit u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .iss_valid_i (iss_valid_i),
      .iss_addr_i  (iss_addr_i),
      .iss_guard_i (iss_guard_i),
      .iss_dst_i   (iss_dst_i),
      .iss_big_i   (iss_big_i),
      .mem_req_o   (mem_req_o),
      .mem_addr_o  (mem_addr_o),
      .mem_rdata_i (mem_rdata_i),
      .wr_en_o     (wr_en_o),
      .wr_idx_o    (wr_idx_o),
      .wr_data_o   (wr_data_o),
      .cache_upd_o (cache_upd_o)
   );

   function automatic logic [7:0] mbyte(input logic [31:0] a);
      case (a)
         32'h0000_0d00: return 8'h22;
         32'h0000_0d01: return 8'h11;
         32'h0000_0d04: return 8'h84;
         32'h0000_0d05: return 8'h33;
         default:       return (a[7:0] * 8'd7) ^ 8'hA5;
      endcase
   endfunction

   function automatic logic [31:0] expect_word(input logic [31:0] a, input logic big);
      logic [15:0] h;
      h = big ? {mbyte(a), mbyte(a + 32'd1)} : {mbyte(a + 32'd1), mbyte(a)};
      return {{16{h[15]}}, h};
   endfunction

   // one-cycle synchronous memory model
   always @(posedge clk)
      if (mem_req_o)
         mem_rdata_i <= {mbyte(mem_addr_o + 32'd1), mbyte(mem_addr_o)};

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(mem_req_o == 1'b0, "R1 req in reset", 32'(mem_req_o), 0);
      chk(wr_en_o == 1'b0, "R1 write in reset", 32'(wr_en_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cache_upd_o == 1'b0, "R1 cache after reset", 32'(cache_upd_o), 0);
   endtask

   // one load, checked at request time and result time
   task automatic t_single(input logic [31:0] a, input logic g, input logic big,
                           input logic [6:0] idx, input logic [31:0] exp_data,
                           input logic exp_req, input logic exp_cache, input string tag);
      @(negedge clk);
      iss_valid_i = 1'b1; iss_addr_i = a; iss_guard_i = g;
      iss_big_i = big; iss_dst_i = idx;
      @(negedge clk);
      iss_valid_i = 1'b0; iss_guard_i = 1'b0;
      iss_big_i = ~big; iss_dst_i = ~idx;
      chk(mem_req_o == exp_req, {tag, " R7 request"}, 32'(mem_req_o), 32'(exp_req));
      if (exp_req)
         chk(mem_addr_o == a, {tag, " R7 address"}, mem_addr_o, a);
      repeat (2) @(negedge clk);
      chk(wr_en_o == 1'b0, {tag, " R2 not early"}, 32'(wr_en_o), 0);
      @(negedge clk);
      chk(wr_en_o == g, {tag, " R2 write strobe"}, 32'(wr_en_o), 32'(g));
      chk(cache_upd_o == exp_cache, {tag, " R8 cache strobe"}, 32'(cache_upd_o),
          32'(exp_cache));
      if (g) begin
         chk(wr_data_o == exp_data, {tag, " data"}, wr_data_o, exp_data);
         chk(wr_idx_o == idx, {tag, " R11 index"}, 32'(wr_idx_o), 32'(idx));
      end
      @(negedge clk);
      chk(wr_en_o == 1'b0, {tag, " R2 single pulse"}, 32'(wr_en_o), 0);
   endtask

   // four back-to-back loads with order and index changing every cycle
   task automatic t_stream;
      logic [31:0] a [4];
      logic        bg[4];
      logic        gd[4];
      a[0] = 32'h0000_0d04; bg[0] = 1'b1; gd[0] = 1'b1;
      a[1] = 32'h0000_0d04; bg[1] = 1'b0; gd[1] = 1'b1;
      a[2] = 32'h0000_0123; bg[2] = 1'b1; gd[2] = 1'b0;
      a[3] = 32'h0000_0d00; bg[3] = 1'b0; gd[3] = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         iss_valid_i = 1'b1; iss_addr_i = a[i]; iss_big_i = bg[i];
         iss_guard_i = gd[i]; iss_dst_i = 7'(10 + i);
      end
      @(negedge clk);
      iss_valid_i = 1'b0; iss_guard_i = 1'b0;
      for (int i = 0; i < 4; i++) begin
         if (i > 0) @(negedge clk);
         chk(wr_en_o == gd[i], "R2 R6 stream strobe", 32'(wr_en_o), 32'(gd[i]));
         if (gd[i]) begin
            chk(wr_data_o == expect_word(a[i], bg[i]), "R11 stream data", wr_data_o,
                expect_word(a[i], bg[i]));
            chk(wr_idx_o == 7'(10 + i), "R11 stream index", 32'(wr_idx_o), 32'(10 + i));
         end
      end
   endtask

   // reset while a load is in flight
   task automatic t_reset_inflight;
      bit seen = 1'b0;
      @(negedge clk);
      iss_valid_i = 1'b1; iss_addr_i = 32'h0000_0d00; iss_guard_i = 1'b1;
      iss_dst_i = 7'd5;
      @(negedge clk);
      iss_valid_i = 1'b0; iss_guard_i = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (wr_en_o || cache_upd_o || mem_req_o) seen = 1'b1;
      end
      chk(!seen, "R1 in-flight load dropped", 32'(seen), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      report();
   end

   initial begin
      t_reset();
      // R3 little-endian: byte at A low
      t_single(32'h0000_0d00, 1'b1, 1'b0, 7'd60, 32'h0000_1122, 1'b1, 1'b1, "R3 LE");
      // R4 big-endian: byte at A high
      t_single(32'h0000_0d00, 1'b1, 1'b1, 7'd61, 32'h0000_2211, 1'b1, 1'b1, "R4 BE");
      // R5 negative halfword sign-extends
      t_single(32'h0000_0d04, 1'b1, 1'b1, 7'd80, 32'hffff_8433, 1'b1, 1'b1, "R5 sign");
      t_single(32'h0000_0d04, 1'b1, 1'b0, 7'd81, 32'h0000_3384, 1'b1, 1'b1, "R5 positive");
      // R6 guard false: nothing happens
      t_single(32'h0000_0d04, 1'b0, 1'b1, 7'd70, 32'h0, 1'b0, 1'b0, "R6 guard off");
      // R9 I/O window: no request, zero data, no cache strobe
      t_single(32'hEFE0_1000, 1'b1, 1'b0, 7'd33, 32'h0, 1'b0, 1'b0, "R9 window");
      // R10 odd address
      t_single(32'h0000_0d01, 1'b1, 1'b0, 7'd90, expect_word(32'h0000_0d01, 1'b0),
               1'b1, 1'b1, "R10 odd LE");
      t_single(32'h0000_0e7f, 1'b1, 1'b1, 7'd91, expect_word(32'h0000_0e7f, 1'b1),
               1'b1, 1'b1, "R10 odd BE");
      t_stream();
      t_reset_inflight();
      repeat (2) @(negedge clk);
      report();
   end
endmodule